// File: doc/BRIEF.md
# Nibble Bus Tone Transceiver Register Interface

This block sits between a host processor and the tone detector and tone generator of a telephone tone transceiver. The host reaches four registers over a 4-bit data bus. A chip-select, a data strobe, a register-select line and a read/write line qualify each access. Writes go either to the transmit digit register or to a pair of control registers that share one address. Reads return either the last received digit or a status nibble. A read result comes back as a one-cycle valid pulse with its data, so the host side stays a simple stream.

The tone detector reports three things through single-cycle strobes: a valid digit with its code, a validated loss of tone, and (from the generator) the end of a timed burst. The detector cannot be stalled, so these inputs are valid-only with no ready. Every strobe is accepted in the cycle it arrives. The block latches the digit and keeps four status flags, each with its own clearing rule. It drives a single active-low, open-drain interrupt request. In call-progress mode that request can instead follow a call-progress square wave.

All state changes on the rising clock edge in which an access or strobe is seen. A bus access counts in each cycle in which the chip-select is low and the strobe is high.

Top module: `nbus_regif`

## Requirements
- R1: After reset, every control bit is 0, the control pointer selects register A, all status flags are 0, `irq_pull` is 0 and a status read returns 4'b0000.
- R2: An access with `bus_sel`=0 and `bus_rd`=0 stores `bus_wdata` into `tx_digit` and pulses `tx_load` high for one cycle, both visible one cycle after the access.
- R3: An access with `bus_rd`=1 gives `bus_rvalid` high for one cycle one cycle later, with `bus_rdata` taken from the received digit when `bus_sel`=0 and from the status nibble when `bus_sel`=1. The status nibble is bit0 event pending, bit1 transmit ready, bit2 digit waiting, bit3 tone absent.
- R4: When the pointer selects A, a control access (`bus_sel`=1, `bus_rd`=0) loads A: bit0 `tone_en`, bit1 `cp_mode`, bit2 interrupt enable. Bit3=1 moves the pointer to B and bit3=0 leaves it on A.
- R5: When the pointer selects B, a control access loads B: bit0 `rx_test`, bit1 `burst_en`, bit2 `single_tone`, bit3 ignored. The pointer then returns to A and register A keeps its contents.
- R6: `rx_dv` latches `rx_digit` and sets digit waiting. A received-digit read clears digit waiting.
- R7: `rx_absent` sets tone absent. A status read clears event pending, transmit ready and tone absent, and returns their values from before the clear.
- R8: `tx_burst_done` sets transmit ready only while `burst_en` is 1. Transmit ready is cleared whenever `burst_en` is 0.
- R9: Event pending is set by `rx_dv`, by `rx_absent`, and by `tx_burst_done` while `burst_en` is 1. With `cp_mode`=0, `irq_pull` (1 means the pin is pulled low) is high exactly while the interrupt enable is set and an event is pending.
- R10: With `cp_mode`=1 and the interrupt enable set, `irq_pull` is the inverse of `cp_wave`, so the pin follows the wave. With the interrupt enable clear, `irq_pull` is 0.
- R11: An access with `bus_cs_n`=1 or `bus_strobe`=0 changes no register.
- R12: A flag set event and a clear in the same cycle leave the flag set. A read in that cycle returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_strobe | input | 1 | Data strobe, access when high with chip select |
| bus_sel | input | 1 | Register select: 0 data registers, 1 control/status |
| bus_rd | input | 1 | 1 read, 0 write |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble |
| bus_rvalid | output | 1 | Read data valid, one-cycle pulse |
| rx_dv | input | 1 | Detector strobe: valid digit present |
| rx_digit | input | 4 | Detected digit code |
| rx_absent | input | 1 | Detector strobe: tone absence validated |
| tx_burst_done | input | 1 | Generator strobe: timed burst finished |
| cp_wave | input | 1 | Call-progress square wave |
| tx_digit | output | 4 | Digit for the tone generator |
| tx_load | output | 1 | New transmit digit pulse |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | 1 call-progress mode, 0 DTMF mode |
| single_tone | output | 1 | Single-tone select |
| burst_en | output | 1 | Burst timing enable |
| rx_test | output | 1 | Receiver test select |
| irq_pull | output | 1 | Open-drain interrupt pull-down enable |

## Verification
Every registered result appears one clock after the edge that samples its access or strobe. This covers read data with its valid pulse, transmit digit and load pulse, control bits and status flags. `irq_pull` follows the flags and `cp_wave` without a further register. The bench drives inputs on the falling edge and holds them for one full cycle. It samples on the next falling edge, which is exactly one register stage later. Read results go into a scoreboard queue when the access is issued, and the monitor compares them on the falling edge where `bus_rvalid` shows.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    ACC_TX_WR = 2'b00,
    ACC_RX_RD = 2'b01,
    ACC_CT_WR = 2'b10,
    ACC_ST_RD = 2'b11
  } acc_e;

  typedef struct packed {
    logic tone_en;
    logic cp_mode;
    logic irq_en;
    logic rx_test;
    logic burst_en;
    logic single_tone;
  } ctrl_t;

  localparam int ST_EVT = 0;
  localparam int ST_TXR = 1;
  localparam int ST_RXF = 2;
  localparam int ST_ABS = 3;
endpackage

// File: rtl/nbus_decode.sv
module nbus_decode
  import nbus_pkg::*;
(
  input  logic cs_n,
  input  logic strobe,
  input  logic sel,
  input  logic rd,
  output logic tx_wr,
  output logic rx_rd,
  output logic ct_wr,
  output logic st_rd
);
  logic  hit;
  acc_e  kind;

  always_comb begin
    hit   = !cs_n && strobe;
    kind  = acc_e'({sel, rd});
    tx_wr = hit && (kind == ACC_TX_WR);
    rx_rd = hit && (kind == ACC_RX_RD);
    ct_wr = hit && (kind == ACC_CT_WR);
    st_rd = hit && (kind == ACC_ST_RD);
  end
endmodule

// File: rtl/nbus_ctrl.sv
module nbus_ctrl
  import nbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ct_wr,
  input  logic [NIB_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic             ptr_b
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      ptr_b <= 1'b0;
    end else if (ct_wr) begin
      if (!ptr_b) begin
        ctrl.tone_en <= wdata[0];
        ctrl.cp_mode <= wdata[1];
        ctrl.irq_en  <= wdata[2];
        ptr_b        <= wdata[3];
      end else begin
        ctrl.rx_test     <= wdata[0];
        ctrl.burst_en    <= wdata[1];
        ctrl.single_tone <= wdata[2];
        ptr_b            <= 1'b0;
      end
    end
  end

  a_r4_goto_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_wr && !ptr_b && wdata[3]) |=> ptr_b);
  a_r5_back_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_wr && ptr_b) |=> !ptr_b);
  a_r5_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_wr && ptr_b) |=> $stable({ctrl.tone_en, ctrl.cp_mode, ctrl.irq_en}));
endmodule

// File: rtl/nbus_status.sv
module nbus_status
  import nbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_rd,
  input  logic             st_rd,
  input  logic             dig_dv,
  input  logic [NIB_W-1:0] dig_code,
  input  logic             absent,
  input  logic             burst_done,
  input  logic             burst_en,
  output logic [NIB_W-1:0] rx_q,
  output logic [NIB_W-1:0] status
);
  logic evt_q, txr_q, rxf_q, abs_q;
  logic burst_ev, any_ev;

  always_comb begin
    burst_ev = burst_done && burst_en;
    any_ev   = dig_dv || absent || burst_ev;
    status          = '0;
    status[ST_EVT]  = evt_q;
    status[ST_TXR]  = txr_q;
    status[ST_RXF]  = rxf_q;
    status[ST_ABS]  = abs_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q  <= '0;
      evt_q <= 1'b0;
      txr_q <= 1'b0;
      rxf_q <= 1'b0;
      abs_q <= 1'b0;
    end else begin
      if (dig_dv) rx_q <= dig_code;
      // set has priority over every clear
      if (dig_dv)      rxf_q <= 1'b1;
      else if (rx_rd)  rxf_q <= 1'b0;
      if (absent)      abs_q <= 1'b1;
      else if (st_rd)  abs_q <= 1'b0;
      if (burst_ev)                 txr_q <= 1'b1;
      else if (st_rd || !burst_en)  txr_q <= 1'b0;
      if (any_ev)      evt_q <= 1'b1;
      else if (st_rd)  evt_q <= 1'b0;
    end
  end

  a_r6_digit_latched: assert property (@(posedge clk) disable iff (!rst_n)
    dig_dv |=> (rxf_q && rx_q == $past(dig_code)));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !dig_dv) |=> !rxf_q);
  a_r7_absent_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !absent) |=> !abs_q);
  a_r8_nonburst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> !txr_q);
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && any_ev) |=> evt_q);
endmodule

// File: rtl/nbus_regif.sv
module nbus_regif
  import nbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs_n,
  input  logic             bus_strobe,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic [NIB_W-1:0] bus_wdata,
  output logic [NIB_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic             rx_dv,
  input  logic [NIB_W-1:0] rx_digit,
  input  logic             rx_absent,
  input  logic             tx_burst_done,
  input  logic             cp_wave,
  output logic [NIB_W-1:0] tx_digit,
  output logic             tx_load,
  output logic             tone_en,
  output logic             cp_mode,
  output logic             single_tone,
  output logic             burst_en,
  output logic             rx_test,
  output logic             irq_pull
);
  logic             tx_wr, rx_rd, ct_wr, st_rd;
  ctrl_t            ctrl;
  logic             ptr_b;
  logic [NIB_W-1:0] rx_q, status;

  nbus_decode u_dec (
    .cs_n(bus_cs_n), .strobe(bus_strobe), .sel(bus_sel), .rd(bus_rd),
    .tx_wr(tx_wr), .rx_rd(rx_rd), .ct_wr(ct_wr), .st_rd(st_rd)
  );

  nbus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ct_wr(ct_wr), .wdata(bus_wdata),
    .ctrl(ctrl), .ptr_b(ptr_b)
  );

  nbus_status u_stat (
    .clk(clk), .rst_n(rst_n), .rx_rd(rx_rd), .st_rd(st_rd),
    .dig_dv(rx_dv), .dig_code(rx_digit), .absent(rx_absent),
    .burst_done(tx_burst_done), .burst_en(ctrl.burst_en),
    .rx_q(rx_q), .status(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_digit   <= '0;
      tx_load    <= 1'b0;
    end else begin
      bus_rvalid <= rx_rd || st_rd;
      tx_load    <= tx_wr;
      if (rx_rd)      bus_rdata <= rx_q;
      else if (st_rd) bus_rdata <= status;
      if (tx_wr)      tx_digit  <= bus_wdata;
    end
  end

  always_comb begin
    tone_en     = ctrl.tone_en;
    cp_mode     = ctrl.cp_mode;
    single_tone = ctrl.single_tone;
    burst_en    = ctrl.burst_en;
    rx_test     = ctrl.rx_test;
    if (!ctrl.irq_en)      irq_pull = 1'b0;
    else if (ctrl.cp_mode) irq_pull = !cp_wave;
    else                   irq_pull = status[ST_EVT];
  end

  a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_wr, rx_rd, ct_wr, st_rd}));
  a_r2_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (tx_load && tx_digit == $past(bus_wdata)));
  a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd || st_rd) |=> bus_rvalid);
  a_r9_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !rx_dv && !rx_absent && !tx_burst_done && !ctrl.cp_mode) |=> !irq_pull);
endmodule

// File: tb/nbus_regif_test.sv
module nbus_regif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs_n = 1'b1, bus_strobe = 1'b0, bus_sel = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_wdata = '0, rx_digit = '0;
  logic       rx_dv = 1'b0, rx_absent = 1'b0, tx_burst_done = 1'b0, cp_wave = 1'b1;
  logic [3:0] bus_rdata, tx_digit;
  logic       bus_rvalid, tx_load, tone_en, cp_mode, single_tone, burst_en, rx_test, irq_pull;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = !clk;

  nbus_regif uut (.*);

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic s, input logic r, input logic [3:0] d);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_strobe = 1'b1; bus_sel = s; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_strobe = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [3:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    acc(s, 1'b1, 4'h0);
  endtask

  task automatic pulse_dv(input logic [3:0] d);
    @(negedge clk); rx_dv = 1'b1; rx_digit = d;
    @(negedge clk); rx_dv = 1'b0;
  endtask

  task automatic pulse_abs();
    @(negedge clk); rx_absent = 1'b1;
    @(negedge clk); rx_absent = 1'b0;
  endtask

  task automatic pulse_bd();
    @(negedge clk); tx_burst_done = 1'b1;
    @(negedge clk); tx_burst_done = 1'b0;
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) chk("R3 pending reads", 4'(exp_q.size()), 4'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", bus_rdata, 4'hx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl bits", {tone_en, cp_mode, single_tone, burst_en}, 4'h0);
    chk("R1 irq/rvalid/txload", {rx_test, irq_pull, bus_rvalid, tx_load}, 4'h0);
    rd(1'b1, 4'h0, "R1 status after reset");

    acc(1'b0, 1'b0, 4'hA);
    chk("R2 tx_digit", tx_digit, 4'hA);
    chk("R2 tx_load pulse", {3'b0, tx_load}, 4'h1);
    @(negedge clk);
    chk("R2 tx_load one cycle", {3'b0, tx_load}, 4'h0);

    @(negedge clk); bus_cs_n = 1'b1; bus_strobe = 1'b1; bus_sel = 1'b0; bus_rd = 1'b0; bus_wdata = 4'h5;
    @(negedge clk); bus_strobe = 1'b0;
    chk("R11 cs high ignored", tx_digit, 4'hA);
    @(negedge clk); bus_cs_n = 1'b0; bus_strobe = 1'b0; bus_sel = 1'b1; bus_wdata = 4'hF;
    @(negedge clk); bus_cs_n = 1'b1;
    chk("R11 strobe low ignored", {tone_en, cp_mode, single_tone, burst_en}, 4'h0);

    acc(1'b1, 1'b0, 4'hD);
    chk("R4 reg A load", {tone_en, cp_mode, single_tone, burst_en}, 4'h8);
    acc(1'b1, 1'b0, 4'h6);
    chk("R5 reg B load", {rx_test, burst_en, single_tone, tone_en}, 4'h7);
    acc(1'b1, 1'b0, 4'h2);
    chk("R5 pointer back to A", {tone_en, cp_mode, burst_en, single_tone}, 4'h7);
    acc(1'b1, 1'b0, 4'h2);
    chk("R4 bit3 low stays on A", {tone_en, cp_mode, burst_en, single_tone}, 4'h7);
    acc(1'b1, 1'b0, 4'h4);

    pulse_dv(4'h7);
    chk("R9 irq on digit", {3'b0, irq_pull}, 4'h1);
    rd(1'b1, 4'b0101, "R6 status digit waiting");
    chk("R9 irq released by status read", {3'b0, irq_pull}, 4'h0);
    rd(1'b1, 4'b0100, "R7 event cleared, digit kept");
    rd(1'b0, 4'h7, "R3 received digit");
    rd(1'b1, 4'b0000, "R6 digit read clears");

    pulse_abs();
    rd(1'b1, 4'b1001, "R7 tone absent");
    rd(1'b1, 4'b0000, "R7 absent cleared");

    pulse_bd();
    rd(1'b1, 4'b0011, "R8 burst done");
    pulse_bd();
    acc(1'b1, 1'b0, 4'hC);
    acc(1'b1, 1'b0, 4'h0);
    chk("R8 burst disabled", {3'b0, burst_en}, 4'h0);
    rd(1'b1, 4'b0001, "R8 tx ready cleared in non-burst");
    pulse_bd();
    rd(1'b1, 4'b0000, "R8 burst done ignored");

    @(negedge clk);
    bus_cs_n = 1'b0; bus_strobe = 1'b1; bus_sel = 1'b0; bus_rd = 1'b1;
    rx_dv = 1'b1; rx_digit = 4'h3;
    exp_q.push_back(4'h7); tag_q.push_back("R12 read returns old digit");
    @(negedge clk);
    bus_cs_n = 1'b1; bus_strobe = 1'b0; rx_dv = 1'b0;
    rd(1'b1, 4'b0101, "R12 set beats read clear");
    rd(1'b0, 4'h3, "R12 new digit kept");

    acc(1'b1, 1'b0, 4'h6);
    cp_wave = 1'b1; #1;
    chk("R10 wave high pin released", {3'b0, irq_pull}, 4'h0);
    cp_wave = 1'b0; #1;
    chk("R10 wave low pin pulled", {3'b0, irq_pull}, 4'h1);
    acc(1'b1, 1'b0, 4'h2);
    chk("R10 irq disabled in cp mode", {3'b0, irq_pull}, 4'h0);

    acc(1'b1, 1'b0, 4'h0);
    pulse_dv(4'h1);
    chk("R9 masked when disabled", {3'b0, irq_pull}, 4'h0);
    acc(1'b1, 1'b0, 4'h4);
    chk("R9 pending event asserts on enable", {3'b0, irq_pull}, 4'h1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule